// File: doc/BRIEF.md
# Coherent Request Generator for a Direct-Mapped Cache

This block sits beside a direct-mapped data cache controller and decides which coherence request goes to the interconnect for each cache event. It keeps a MESI state and a tag for every line. The cache controller reports one event at a time: a read miss, a write miss, a write hit, or a plain replacement of a line. Each event carries the line index and the physical line address, which is the byte address without its 6 offset bits. The block then issues zero, one or two requests over a valid/ready handshake and raises a one-cycle done pulse when the event is complete.

Request addresses are always line-aligned 32-bit addresses. Fills and upgrades use the event's line address. A victim's address is rebuilt from the tag stored for that index. When a miss lands on an occupied line, the victim request goes first and the fill follows it. A read fill can be granted exclusively by the responder, which leaves the line clean and unique rather than shared.

Top module: `coh_req_gen`

## Requirements
- R1: After reset every line is INVALID (line state encoding MODIFIED=0, EXCLUSIVE=1, SHARED=2, INVALID=3). `req_valid` and `done` are low and `evt_ready` is high.
- R2: A read miss (`evt_kind`=0) issues READ_SHARED (`req_op`=0) at {line address, 6'b0}. On acknowledge the line becomes SHARED, or EXCLUSIVE if `resp_excl` is high in the acknowledge cycle.
- R3: A write miss (`evt_kind`=1) issues READ_UNIQUE (`req_op`=1) at the aligned line address. The line becomes MODIFIED on acknowledge.
- R4: A write hit (`evt_kind`=2) on a SHARED line issues CLEAN_UNIQUE (`req_op`=2). `done` comes only in the acknowledge cycle, and the line becomes MODIFIED.
- R5: A write hit on an EXCLUSIVE line makes it MODIFIED, and a write hit on a MODIFIED line leaves it MODIFIED. Neither issues a request, and `done` pulses in the cycle after acceptance.
- R6: Replacing a valid line, either as a replace event (`evt_kind`=3) or as the victim of a miss, issues EVICT (`req_op`=3) for a SHARED or EXCLUSIVE line and WRITE_BACK_FULL (`req_op`=4) for a MODIFIED line. The address is {stored tag, index, 6'b0}, and the line becomes INVALID.
- R7: An INVALID line produces no victim request. A replace event on it completes with `done` in the cycle after acceptance.
- R8: When a miss displaces a valid line, the victim request is acknowledged first without `done`. The fill request follows, and `done` comes with the fill's acknowledge.
- R9: `req_valid` stays high with stable `req_op` and `req_addr` until `req_ready` is sampled high. The line update and `done` occur in that cycle.
- R10: `evt_ready` is low from acceptance until `done`, and events offered in that time are ignored.
- R11: A write hit on an INVALID line is handled as a write miss (READ_UNIQUE, then MODIFIED).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Block idle, event accepted when valid |
| evt_kind | input | 2 | 0 read miss, 1 write miss, 2 write hit, 3 replace |
| evt_idx | input | IDX_W (4) | Line index |
| evt_line | input | ADDR_W-OFF_W (26) | Physical line address {tag, index} |
| req_valid | output | 1 | Coherence request valid |
| req_ready | input | 1 | Interconnect accepts and completes request |
| req_op | output | 3 | Request opcode |
| req_addr | output | ADDR_W (32) | Line-aligned request address |
| resp_excl | input | 1 | Read fill granted as unique clean |
| done | output | 1 | Event complete pulse |

## Verification
Read-miss, write-miss and write-hit patterns are applied to lines that are first brought into SHARED, EXCLUSIVE or MODIFIED. Each line's state is then read back through the request that a later write hit or replace produces. This separates a state update that happened from one that was skipped. Misses on occupied lines separate the victim-then-fill ordering, and the clean and dirty victim opcodes, from a fill issued directly. Acknowledges are held back to expose request stability and the point at which `done` arrives, while an event is offered during the wait to show that it is ignored.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LS_MOD = 2'd0,
    LS_EXC = 2'd1,
    LS_SHR = 2'd2,
    LS_INV = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    EV_RD_MISS = 2'd0,
    EV_WR_MISS = 2'd1,
    EV_WR_HIT  = 2'd2,
    EV_REPLACE = 2'd3
  } evt_kind_e;

  typedef enum logic [2:0] {
    OP_RD_SHARED   = 3'd0,
    OP_RD_UNIQUE   = 3'd1,
    OP_CLEAN_UNIQ  = 3'd2,
    OP_EVICT       = 3'd3,
    OP_WB_FULL     = 3'd4
  } coh_op_e;

  typedef struct packed {
    logic     vic_need;
    coh_op_e  vic_op;
    logic     main_need;
    coh_op_e  main_op;
    line_st_e final_st;
  } req_plan_t;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_VIC   = 2'd1,
    FS_MAIN  = 2'd2,
    FS_QUIET = 2'd3
  } fsm_e;

endpackage

// File: rtl/coh_line_table.sv
module coh_line_table
  import coh_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int TAG_W     = 22,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output line_st_e         rd_st,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  line_st_e         wr_st,
  input  logic             wr_tag_en,
  input  logic [TAG_W-1:0] wr_tag
);

  line_st_e         st_q  [NUM_LINES];
  logic [TAG_W-1:0] tag_q [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic hit_w;
    assign hit_w = (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[g] <= LS_INV;
      end else if (wr_en && hit_w) begin
        st_q[g] <= wr_st;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_tag_en && hit_w) begin
        tag_q[g] <= wr_tag;
      end
    end
  end

  assign rd_st  = st_q[rd_idx];
  assign rd_tag = tag_q[rd_idx];

endmodule

// File: rtl/coh_req_select.sv
module coh_req_select
  import coh_pkg::*;
(
  input  logic [1:0] kind,
  input  line_st_e   cur_st,
  output req_plan_t  plan
);

  always_comb begin
    plan.vic_need  = (evt_kind_e'(kind) != EV_WR_HIT) && (cur_st != LS_INV);
    plan.vic_op    = (cur_st == LS_MOD) ? OP_WB_FULL : OP_EVICT;
    plan.main_need = 1'b0;
    plan.main_op   = OP_RD_SHARED;
    plan.final_st  = LS_INV;
    case (evt_kind_e'(kind))
      EV_RD_MISS: begin
        plan.main_need = 1'b1;
        plan.main_op   = OP_RD_SHARED;
        plan.final_st  = LS_SHR;
      end
      EV_WR_MISS: begin
        plan.main_need = 1'b1;
        plan.main_op   = OP_RD_UNIQUE;
        plan.final_st  = LS_MOD;
      end
      EV_WR_HIT: begin
        plan.final_st = LS_MOD;
        case (cur_st)
          LS_SHR: begin
            plan.main_need = 1'b1;
            plan.main_op   = OP_CLEAN_UNIQ;
          end
          LS_INV: begin
            plan.main_need = 1'b1;
            plan.main_op   = OP_RD_UNIQUE;
          end
          default: plan.main_need = 1'b0;
        endcase
      end
      default: begin
        plan.main_need = 1'b0;
        plan.final_st  = LS_INV;
      end
    endcase
  end

endmodule

// File: rtl/coh_req_gen.sv
module coh_req_gen
  import coh_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 6,
  localparam int IDX_W    = $clog2(NUM_LINES),
  localparam int LA_W     = ADDR_W - OFF_W,
  localparam int TAG_W    = LA_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [1:0]        evt_kind,
  input  logic [IDX_W-1:0]  evt_idx,
  input  logic [LA_W-1:0]   evt_line,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [2:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              resp_excl,
  output logic              done
);

  fsm_e             fsm_q, fsm_d;
  req_plan_t        plan_q, plan_sel;
  logic [IDX_W-1:0] idx_q;
  logic [LA_W-1:0]  line_q;
  logic [TAG_W-1:0] vtag_q;
  logic             cap_en;

  line_st_e         cur_st;
  logic [TAG_W-1:0] cur_tag;
  logic             tw_en, tw_tag_en;
  line_st_e         tw_st;

  coh_line_table #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (evt_idx),
    .rd_st     (cur_st),
    .rd_tag    (cur_tag),
    .wr_en     (tw_en),
    .wr_idx    (idx_q),
    .wr_st     (tw_st),
    .wr_tag_en (tw_tag_en),
    .wr_tag    (line_q[LA_W-1:IDX_W])
  );

  coh_req_select u_sel (
    .kind   (evt_kind),
    .cur_st (cur_st),
    .plan   (plan_sel)
  );

  assign cap_en = (fsm_q == FS_IDLE) && evt_valid;

  always_comb begin
    fsm_d     = fsm_q;
    tw_en     = 1'b0;
    tw_tag_en = 1'b0;
    tw_st     = LS_INV;
    done      = 1'b0;
    case (fsm_q)
      FS_IDLE: begin
        if (evt_valid) begin
          if (plan_sel.vic_need)       fsm_d = FS_VIC;
          else if (plan_sel.main_need) fsm_d = FS_MAIN;
          else                         fsm_d = FS_QUIET;
        end
      end
      FS_VIC: begin
        if (req_ready) begin
          tw_en = 1'b1;
          tw_st = LS_INV;
          if (plan_q.main_need) begin
            fsm_d = FS_MAIN;
          end else begin
            fsm_d = FS_IDLE;
            done  = 1'b1;
          end
        end
      end
      FS_MAIN: begin
        if (req_ready) begin
          tw_en     = 1'b1;
          tw_tag_en = 1'b1;
          if (plan_q.main_op == OP_RD_SHARED) tw_st = resp_excl ? LS_EXC : LS_SHR;
          else                                tw_st = plan_q.final_st;
          fsm_d = FS_IDLE;
          done  = 1'b1;
        end
      end
      default: begin
        tw_en = 1'b1;
        tw_st = plan_q.final_st;
        fsm_d = FS_IDLE;
        done  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q <= FS_IDLE;
    end else begin
      fsm_q <= fsm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plan_q <= '0;
      idx_q  <= '0;
      line_q <= '0;
      vtag_q <= '0;
    end else if (cap_en) begin
      plan_q <= plan_sel;
      idx_q  <= evt_idx;
      line_q <= evt_line;
      vtag_q <= cur_tag;
    end
  end

  assign evt_ready = (fsm_q == FS_IDLE);
  assign req_valid = (fsm_q == FS_VIC) || (fsm_q == FS_MAIN);

  always_comb begin
    req_op   = 3'd0;
    req_addr = '0;
    if (fsm_q == FS_VIC) begin
      req_op   = plan_q.vic_op;
      req_addr = {vtag_q, idx_q, {OFF_W{1'b0}}};
    end else if (fsm_q == FS_MAIN) begin
      req_op   = plan_q.main_op;
      req_addr = {line_q, {OFF_W{1'b0}}};
    end
  end

endmodule

// File: rtl/coh_req_gen_chk.sv
module coh_req_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_ready,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic              done
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_op) && $stable(req_addr)); // R9

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && evt_ready); // R9

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !evt_ready); // R10

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[OFF_W-1:0] == '0); // R2

  AST_VICTIM_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_op == 3'd3 || req_op == 3'd4) && !done
      |=> req_valid && (req_op == 3'd0 || req_op == 3'd1)); // R8

  AST_UPGRADE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_op == 3'd2 |-> done); // R4

  AST_OP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_op <= 3'd4); // R6

endmodule

bind coh_req_gen coh_req_gen_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_ready (evt_ready),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .req_addr  (req_addr),
  .done      (done)
);

// File: tb/coh_req_gen_test.sv
`timescale 1ns/1ps
module coh_req_gen_test;

  localparam int IDX_W = 4;
  localparam int LA_W  = 26;
  localparam int TAG_W = 22;

  localparam logic [2:0] RS = 3'd0, RU = 3'd1, CU = 3'd2, EV = 3'd3, WB = 3'd4;
  localparam logic [1:0] K_RD = 2'd0, K_WM = 2'd1, K_WH = 2'd2, K_RP = 2'd3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             evt_valid;
  logic             evt_ready;
  logic [1:0]       evt_kind;
  logic [IDX_W-1:0] evt_idx;
  logic [LA_W-1:0]  evt_line;
  logic             req_valid;
  logic             req_ready;
  logic [2:0]       req_op;
  logic [31:0]      req_addr;
  logic             resp_excl;
  logic             done;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  coh_req_gen uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_kind(evt_kind), .evt_idx(evt_idx), .evt_line(evt_line),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .resp_excl(resp_excl), .done(done)
  );

  function automatic logic [LA_W-1:0] mkl(input logic [TAG_W-1:0] t, input logic [IDX_W-1:0] i);
    return {t, i};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic send_evt(input logic [1:0] k, input logic [IDX_W-1:0] i, input logic [LA_W-1:0] l);
    @(negedge clk);
    evt_valid = 1'b1; evt_kind = k; evt_idx = i; evt_line = l;
    @(negedge clk);
    evt_valid = 1'b0;
    #1;
  endtask

  task automatic expect_req(input logic [2:0] op, input logic [31:0] addr, input int stall,
                            input bit excl, input bit exp_done, input string rq);
    for (int s = 0; s < stall; s++) begin
      chk(req_valid == 1'b1, rq, "valid while stalled", 32'(req_valid), 32'd1);
      chk(req_op == op, rq, "op while stalled", 32'(req_op), 32'(op));
      chk(req_addr == addr, rq, "addr while stalled", req_addr, addr);
      chk(evt_ready == 1'b0, "R10", "evt_ready busy", 32'(evt_ready), 32'd0);
      chk(done == 1'b0, rq, "no done before ack", 32'(done), 32'd0);
      @(negedge clk); #1;
    end
    chk(req_valid == 1'b1, rq, "req_valid", 32'(req_valid), 32'd1);
    chk(req_op == op, rq, "req_op", 32'(req_op), 32'(op));
    chk(req_addr == addr, rq, "req_addr", req_addr, addr);
    req_ready = 1'b1; resp_excl = excl;
    #1;
    chk(done == exp_done, rq, "done at ack", 32'(done), 32'(exp_done));
    @(negedge clk);
    req_ready = 1'b0; resp_excl = 1'b0;
    #1;
  endtask

  task automatic expect_quiet(input string rq);
    chk(req_valid == 1'b0, rq, "no request", 32'(req_valid), 32'd0);
    chk(done == 1'b1, rq, "done next cycle", 32'(done), 32'd1);
    @(negedge clk); #1;
    chk(done == 1'b0 && evt_ready == 1'b1, rq, "back to idle", {30'd0, done, evt_ready}, 32'd1);
  endtask

  task automatic t_reset();
    chk(req_valid == 1'b0, "R1", "req_valid after reset", 32'(req_valid), 32'd0);
    chk(done == 1'b0, "R1", "done after reset", 32'(done), 32'd0);
    chk(evt_ready == 1'b1, "R1", "evt_ready after reset", 32'(evt_ready), 32'd1);
    send_evt(K_RP, 4'd0, mkl(22'h0, 4'd0));
    expect_quiet("R1");
  endtask

  task automatic t_shared_line();
    send_evt(K_RD, 4'd1, mkl(22'h01234, 4'd1));
    expect_req(RS, {mkl(22'h01234, 4'd1), 6'd0}, 0, 1'b0, 1'b1, "R2");
    send_evt(K_WH, 4'd1, mkl(22'h01234, 4'd1));
    expect_req(CU, {mkl(22'h01234, 4'd1), 6'd0}, 2, 1'b0, 1'b1, "R4");
    send_evt(K_WH, 4'd1, mkl(22'h01234, 4'd1));
    expect_quiet("R5");
    send_evt(K_RP, 4'd1, mkl(22'h0, 4'd0));
    expect_req(WB, {mkl(22'h01234, 4'd1), 6'd0}, 0, 1'b0, 1'b1, "R6");
    send_evt(K_RP, 4'd1, mkl(22'h0, 4'd0));
    expect_quiet("R7");
  endtask

  task automatic t_miss_with_victim();
    send_evt(K_WM, 4'd15, mkl(22'h3ABCD, 4'd15));
    expect_req(RU, {mkl(22'h3ABCD, 4'd15), 6'd0}, 0, 1'b0, 1'b1, "R3");
    send_evt(K_RD, 4'd15, mkl(22'h00F0F, 4'd15));
    @(negedge clk);
    evt_valid = 1'b1; evt_kind = K_WM; evt_idx = 4'd15; evt_line = mkl(22'h11111, 4'd15);
    #1;
    expect_req(WB, {mkl(22'h3ABCD, 4'd15), 6'd0}, 1, 1'b0, 1'b0, "R8");
    evt_valid = 1'b0;
    expect_req(RS, {mkl(22'h00F0F, 4'd15), 6'd0}, 0, 1'b0, 1'b1, "R8");
    chk(req_valid == 1'b0, "R10", "ignored event issues nothing", 32'(req_valid), 32'd0);
    send_evt(K_RP, 4'd15, mkl(22'h0, 4'd0));
    expect_req(EV, {mkl(22'h00F0F, 4'd15), 6'd0}, 0, 1'b0, 1'b1, "R6");
  endtask

  task automatic t_exclusive();
    send_evt(K_RD, 4'd4, mkl(22'h2AAAA, 4'd4));
    expect_req(RS, {mkl(22'h2AAAA, 4'd4), 6'd0}, 0, 1'b1, 1'b1, "R2");
    send_evt(K_WH, 4'd4, mkl(22'h2AAAA, 4'd4));
    expect_quiet("R5");
    send_evt(K_RP, 4'd4, mkl(22'h0, 4'd0));
    expect_req(WB, {mkl(22'h2AAAA, 4'd4), 6'd0}, 0, 1'b0, 1'b1, "R5");
    send_evt(K_RD, 4'd5, mkl(22'h15555, 4'd5));
    expect_req(RS, {mkl(22'h15555, 4'd5), 6'd0}, 0, 1'b1, 1'b1, "R2");
    send_evt(K_WM, 4'd5, mkl(22'h00077, 4'd5));
    expect_req(EV, {mkl(22'h15555, 4'd5), 6'd0}, 0, 1'b0, 1'b0, "R6");
    expect_req(RU, {mkl(22'h00077, 4'd5), 6'd0}, 0, 1'b0, 1'b1, "R8");
  endtask

  task automatic t_write_hit_invalid();
    send_evt(K_WH, 4'd6, mkl(22'h0BEEF, 4'd6));
    expect_req(RU, {mkl(22'h0BEEF, 4'd6), 6'd0}, 0, 1'b0, 1'b1, "R11");
    send_evt(K_RP, 4'd6, mkl(22'h0, 4'd0));
    expect_req(WB, {mkl(22'h0BEEF, 4'd6), 6'd0}, 0, 1'b0, 1'b1, "R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt_valid = 1'b0; evt_kind = 2'd0; evt_idx = '0; evt_line = '0;
    req_ready = 1'b0; resp_excl = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_shared_line();
    t_miss_with_victim();
    t_exclusive();
    t_write_hit_invalid();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule